// File: doc/BRIEF.md
# Serial memory read command handler

This block carries out the read-memory command of a byte-serial slave. It sits between a bit-level layer, which delivers whole received bytes and asks for bytes to transmit, and a byte-addressed memory array with a synchronous read port. A command starts when the opcode 0xF0 arrives while the handler is idle. It then takes a two-byte start address. After that, every byte request from the master returns one data byte, and the address moves on by one each time.

Two address ranges never reach the output. The first is a protected secret window, 0x0080 to 0x0087 by default. The second is everything above the last readable address, 0x0097 by default. Both return 0xFF, and no memory access is issued for them. A target-address register is visible at the port. It is loaded with the start address and then tracks the address of the most recently delivered byte, not the next one. A bus reset pulse drops the command at any point.

Top module: `memrd_cmd_handler`

## Requirements
- R1: After reset, tx_valid and mem_rd_en are 0 and tgt_addr is 0x0000.
- R2: In idle, only a received byte equal to 0xF0 starts a command. Any other byte leaves the handler idle, and a later tx_req then gets no response.
- R3: After the opcode, the next received byte is the low address byte and the one after it is the high byte. tgt_addr shows the full start address from the cycle after the high byte is taken. A tx_req before both address bytes have arrived gets no response.
- R4: Once the address is complete, each tx_req cycle produces exactly one tx_valid pulse, in the following cycle. Successive requests cover consecutive addresses, starting at the start address.
- R5: For a readable address, mem_rd_en is high with mem_addr equal to that address in the tx_req cycle, and tx_byte in the tx_valid cycle equals the memory data returned one cycle later.
- R6: Addresses from SECRET_LO to SECRET_HI (default 0x0080 to 0x0087) return 0xFF and never raise mem_rd_en.
- R7: Addresses above LAST_ADDR (default 0x0097) return 0xFF and never raise mem_rd_en.
- R8: The cycle after a tx_valid pulse, tgt_addr holds the address of the byte just delivered.
- R9: bus_rst returns the handler to idle from any state. Later tx_req pulses get no response until a new opcode and address arrive, and tgt_addr is left unchanged.
- R10: Bytes received while data is streaming are ignored and do not disturb the address sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | Bus reset pulse from the bit layer; aborts the command |
| rx_valid | input | 1 | A received byte is present on rx_byte |
| rx_byte | input | 8 | Received byte (opcode or address) |
| tx_req | input | 1 | Master asks for the next data byte |
| tx_valid | output | 1 | tx_byte holds the requested byte |
| tx_byte | output | 8 | Data byte returned to the bit layer |
| mem_rd_en | output | 1 | Read strobe to the memory array |
| mem_addr | output | ADDR_W | Read address to the memory array |
| mem_rdata | input | 8 | Memory data, valid one cycle after mem_rd_en |
| tgt_addr | output | ADDR_W | Target address register: start address, then the last byte read |

## Verification
The bench aims at the edges of the two masked ranges: 0x007F/0x0080, 0x0087/0x0088 and 0x0097/0x0098. An off-by-one range compare would leak one secret byte or cut off a valid one there, and a memory strobe issued for a masked address shows up directly at the memory port. The bench also checks tgt_addr after every delivered byte, which exposes a design that keeps the next address instead of the last one. Finally, it sends stray opcodes, early tx_req pulses, stray received bytes during streaming and bus resets in mid-address and mid-stream. A handler that leaves idle on any byte, responds before the address is complete, or lets a bus reset change state would produce a tx_valid that the bench does not expect.

// File: rtl/memrd_pkg.sv
package memrd_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_ADR_LO  = 3'd1,
      ST_ADR_HI  = 3'd2,
      ST_STREAM  = 3'd3,
      ST_DELIVER = 3'd4
   } rd_state_e;
endpackage

// File: rtl/memrd_seq.sv
module memrd_seq
   import memrd_pkg::*;
#(
   parameter logic [BYTE_W-1:0] OPCODE = 8'hF0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rst,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              tx_req,
   output rd_state_e         state_o,
   output logic              lo_cap,
   output logic              hi_cap,
   output logic              issue,
   output logic              deliver
);
   rd_state_e state_q, state_d;

   assign lo_cap  = !bus_rst && rx_valid && (state_q == ST_ADR_LO);
   assign hi_cap  = !bus_rst && rx_valid && (state_q == ST_ADR_HI);
   assign issue   = !bus_rst && tx_req   && (state_q == ST_STREAM);
   assign deliver = !bus_rst && (state_q == ST_DELIVER);
   assign state_o = state_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (rx_valid && rx_byte == OPCODE) state_d = ST_ADR_LO;
         ST_ADR_LO:  if (rx_valid) state_d = ST_ADR_HI;
         ST_ADR_HI:  if (rx_valid) state_d = ST_STREAM;
         ST_STREAM:  if (tx_req) state_d = ST_DELIVER;
         ST_DELIVER: state_d = ST_STREAM;
         default:    state_d = ST_IDLE;
      endcase
      if (bus_rst) state_d = ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   // R9: a bus reset always lands in idle
   a_r9_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst |=> (state_q == ST_IDLE));
   // R4: an accepted request moves to the delivery cycle
   a_r4_req_delivers: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_STREAM && tx_req && !bus_rst) |=> (state_q == ST_DELIVER));
   // R2: idle is left only on the opcode
   a_r2_idle_needs_opcode: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !(rx_valid && rx_byte == OPCODE)) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/memrd_addr.sv
module memrd_addr
   import memrd_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lo_cap,
   input  logic              hi_cap,
   input  logic              deliver,
   input  logic [BYTE_W-1:0] rx_byte,
   output logic [ADDR_W-1:0] ptr,
   output logic [ADDR_W-1:0] tgt
);
   localparam int HI_W = ADDR_W - BYTE_W;
   localparam logic [ADDR_W-1:0] PTR_MAX = {ADDR_W{1'b1}};

   logic [BYTE_W-1:0] lo_q;
   logic [ADDR_W-1:0] start_addr;

   assign start_addr = {rx_byte[HI_W-1:0], lo_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         ptr  <= '0;
         tgt  <= '0;
      end else begin
         if (lo_cap) lo_q <= rx_byte;
         if (hi_cap) begin
            ptr <= start_addr;
            tgt <= start_addr;
         end else if (deliver) begin
            tgt <= ptr;
            if (ptr != PTR_MAX) ptr <= ptr + 1'b1;
         end
      end
   end

   // R4: the next-read pointer never moves backwards while streaming
   a_r4_ptr_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      (deliver && !hi_cap) |=> (ptr >= $past(ptr)));
endmodule

// File: rtl/memrd_gate.sv
module memrd_gate #(
   parameter int          ADDR_W      = 16,
   parameter int unsigned LAST_ADDR   = 32'h97,
   parameter int unsigned SECRET_LO   = 32'h80,
   parameter int unsigned SECRET_HI   = 32'h87,
   parameter bit          MASK_SECRET = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              readable
);
   localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_ADDR);
   localparam logic [ADDR_W-1:0] SEC_LO = ADDR_W'(SECRET_LO);
   localparam logic [ADDR_W-1:0] SEC_HI = ADDR_W'(SECRET_HI);

   logic in_range, in_secret;

   assign in_range = (addr <= LAST_A);

   generate
      if (MASK_SECRET) begin : g_mask
         assign in_secret = (addr >= SEC_LO) && (addr <= SEC_HI);
      end else begin : g_open
         assign in_secret = 1'b0;
      end
   endgenerate

   assign readable = in_range && !in_secret;
endmodule

// File: rtl/memrd_cmd_handler.sv
module memrd_cmd_handler
   import memrd_pkg::*;
#(
   parameter int                ADDR_W      = 16,
   parameter int unsigned       LAST_ADDR   = 32'h97,
   parameter int unsigned       SECRET_LO   = 32'h80,
   parameter int unsigned       SECRET_HI   = 32'h87,
   parameter bit                MASK_SECRET = 1'b1,
   parameter logic [BYTE_W-1:0] OPCODE      = 8'hF0,
   parameter logic [BYTE_W-1:0] FILL        = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rst,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic              tx_req,
   output logic              tx_valid,
   output logic [7:0]        tx_byte,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [7:0]        mem_rdata,
   output logic [ADDR_W-1:0] tgt_addr
);
   generate
      if (ADDR_W <= BYTE_W || ADDR_W > 2 * BYTE_W) begin : g_bad_width
         $error("ADDR_W must lie between 9 and 16");
      end
      if (SECRET_LO > SECRET_HI) begin : g_bad_secret
         $error("SECRET_LO must not exceed SECRET_HI");
      end
      if (LAST_ADDR >= (32'd1 << ADDR_W)) begin : g_bad_last
         $error("LAST_ADDR does not fit in ADDR_W");
      end
   endgenerate

   rd_state_e         state;
   logic              lo_cap, hi_cap, issue, deliver, readable;
   logic [ADDR_W-1:0] ptr;

   memrd_seq #(.OPCODE(OPCODE)) u_seq (
      .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
      .state_o(state), .lo_cap(lo_cap), .hi_cap(hi_cap),
      .issue(issue), .deliver(deliver)
   );

   memrd_addr #(.ADDR_W(ADDR_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .lo_cap(lo_cap), .hi_cap(hi_cap),
      .deliver(deliver), .rx_byte(rx_byte), .ptr(ptr), .tgt(tgt_addr)
   );

   memrd_gate #(
      .ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR), .SECRET_LO(SECRET_LO),
      .SECRET_HI(SECRET_HI), .MASK_SECRET(MASK_SECRET)
   ) u_gate (
      .addr(ptr), .readable(readable)
   );

   assign mem_addr  = ptr;
   assign mem_rd_en = issue && readable;
   assign tx_valid  = deliver;
   assign tx_byte   = readable ? mem_rdata : FILL;

   // R1: nothing is emitted in the first cycle after reset
   a_r1_quiet_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> (!tx_valid && !mem_rd_en));
   // R4: responses are single-cycle pulses
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |=> !tx_valid);
   // R6: the secret window is never fetched
   a_r6_no_secret_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> !(MASK_SECRET && mem_addr >= ADDR_W'(SECRET_LO)
                      && mem_addr <= ADDR_W'(SECRET_HI)));
   // R7: nothing above the last readable address is fetched
   a_r7_no_fetch_beyond: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> (mem_addr <= ADDR_W'(LAST_ADDR)));
   // R8: the target register holds the delivered byte's address
   a_r8_tgt_last_read: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |=> (tgt_addr == $past(mem_addr)));
   // R5: a memory read is always answered in the next cycle
   a_r5_fetch_answered: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && !$past(bus_rst)) |=> (tx_valid || bus_rst));
endmodule

// File: tb/tb_memrd_cmd_handler.sv
module tb_memrd_cmd_handler;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_rst = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = 8'h00;
   logic        tx_req = 1'b0;
   logic        tx_valid;
   logic [7:0]  tx_byte;
   logic        mem_rd_en;
   logic [15:0] mem_addr;
   logic [7:0]  mem_rdata = 8'hC3;
   logic [15:0] tgt_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   memrd_cmd_handler dut (
      .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .rx_valid(rx_valid),
      .rx_byte(rx_byte), .tx_req(tx_req), .tx_valid(tx_valid), .tx_byte(tx_byte),
      .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .tgt_addr(tgt_addr)
   );

   function automatic logic [7:0] mem_val(input logic [15:0] a);
      return {1'b0, a[6:0] ^ 7'h2A ^ a[14:8]};
   endfunction

   function automatic bit can_read(input logic [15:0] a);
      return (a <= 16'h0097) && !(a >= 16'h0080 && a <= 16'h0087);
   endfunction

   function automatic logic [7:0] exp_byte(input logic [15:0] a);
      return can_read(a) ? mem_val(a) : 8'hFF;
   endfunction

   // memory model: one-cycle read latency, junk when not strobed
   always @(posedge clk) mem_rdata <= mem_rd_en ? mem_val(mem_addr) : 8'hC3;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk); rx_valid = 1'b1; rx_byte = b;
      @(negedge clk); rx_valid = 1'b0;
   endtask

   task automatic pulse_bus_rst();
      @(negedge clk); bus_rst = 1'b1;
      @(negedge clk); bus_rst = 1'b0;
   endtask

   task automatic open_at(input logic [15:0] a);
      send(8'hF0); send(a[7:0]); send(a[15:8]);
      chk(tgt_addr == a, "R3 start address", tgt_addr, a);
   endtask

   task automatic read_one(input logic [15:0] a, input string req);
      @(negedge clk); tx_req = 1'b1; #1;
      chk(mem_rd_en == can_read(a), {req, " R5 strobe"}, mem_rd_en, can_read(a));
      if (can_read(a)) chk(mem_addr == a, "R5 mem_addr", mem_addr, a);
      @(negedge clk); tx_req = 1'b0;
      chk(tx_valid == 1'b1, "R4 tx_valid", tx_valid, 1);
      chk(tx_byte == exp_byte(a), req, tx_byte, exp_byte(a));
      @(negedge clk);
      chk(tgt_addr == a, "R8 last read", tgt_addr, a);
   endtask

   task automatic expect_silence(input string req);
      @(negedge clk); tx_req = 1'b1; #1;
      chk(mem_rd_en == 1'b0, {req, " strobe"}, mem_rd_en, 0);
      @(negedge clk); tx_req = 1'b0;
      chk(tx_valid == 1'b0, req, tx_valid, 0);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual 0 expected 1");
         finish_run();
      end
   end

   initial begin
      logic [15:0] start, hold;
      int len;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
      chk(mem_rd_en == 1'b0, "R1 mem_rd_en", mem_rd_en, 0);
      chk(tgt_addr == 16'h0000, "R1 tgt_addr", tgt_addr, 0);
      rst_n = 1'b1;

      // R2: wrong opcode ignored
      send(8'hAA);
      expect_silence("R2 wrong opcode");

      // R3: request before the high address byte is ignored
      send(8'hF0); send(8'h10);
      expect_silence("R3 early request");
      send(8'h00);
      chk(tgt_addr == 16'h0010, "R3 start address", tgt_addr, 16'h0010);
      for (int i = 0; i < 3; i++) read_one(16'h0010 + 16'(i), "R4 sequential");

      // R6: sweep across both edges of the secret window
      pulse_bus_rst();
      open_at(16'h007D);
      for (int i = 0; i < 13; i++) read_one(16'h007D + 16'(i), "R6 secret edge");

      // R7: sweep across the top of the memory
      pulse_bus_rst();
      open_at(16'h0094);
      for (int i = 0; i < 4; i++) read_one(16'h0094 + 16'(i), "R7 top edge");
      // R10: stray received byte during streaming
      send(8'hF0);
      for (int i = 4; i < 7; i++) read_one(16'h0094 + 16'(i), "R10 stray byte");

      // R9: abort mid-stream; tgt_addr unchanged, requests ignored
      pulse_bus_rst();
      chk(tgt_addr == 16'h009A, "R9 tgt kept", tgt_addr, 16'h009A);
      expect_silence("R9 after abort");
      // R9: abort between the address bytes
      send(8'hF0); send(8'h05);
      pulse_bus_rst();
      send(8'h00);
      expect_silence("R9 abort in address");
      open_at(16'h0000);
      read_one(16'h0000, "R4 address zero");

      // random transactions
      for (int t = 0; t < 40; t++) begin
         pulse_bus_rst();
         start = ($urandom_range(0, 1) == 1) ? 16'($urandom_range(16'h0078, 16'h00A0))
                                            : 16'($urandom_range(0, 16'h01FF));
         len = $urandom_range(1, 10);
         open_at(start);
         for (int i = 0; i < len; i++) begin
            if ($urandom_range(0, 5) == 0) send(8'($urandom));
            read_one(start + 16'(i), "R4 random read");
         end
         if ($urandom_range(0, 3) == 0) begin
            hold = start + 16'(len - 1);
            pulse_bus_rst();
            expect_silence("R9 random abort");
            chk(tgt_addr == hold, "R9 random tgt kept", tgt_addr, hold);
         end
      end

      done = 1'b1;
      finish_run();
   end
endmodule